// File: doc/BRIEF.md
# NAND Block Erase Sequencer

A host-side controller that carries out a single block erase on an 8-bit NAND flash bus. The caller presents an 11-bit block number and pulses `start_i`. The sequencer then keeps chip enable low and runs a fixed series of write cycles. It sends the erase setup command, then three row-address bytes in which the page bits are forced to zero, then the confirm command. The controller waits for ready/busy to fall and then to rise again, sends the status command and performs one read cycle. It reports the outcome with a single-cycle `done_o` pulse.

Every bus phase is a whole number of clock cycles set by a parameter: the setup of the latch-enable strobe and data before WE falls, the WE low time, and the hold after WE rises. Two windows guard the handshake. Ready/busy must fall within `RB_LOW_WIN` clocks of the confirm cycle. It must then rise again within `BUSY_TO` clocks. If either window runs out, the operation ends with a timeout flag and no status read takes place.

Top module: `nand_erase_seq`

## Requirements
- R1: Out of reset the block is idle. `busy_o`, `done_o`, `pass_o`, `fail_o`, `timeout_o`, `nand_cle_o`, `nand_ale_o` and `nand_io_oe_o` are all 0. `nand_ce_no`, `nand_we_no` and `nand_re_no` are all 1.
- R2: A `start_i` sampled while idle raises `busy_o` on the following cycle. `nand_ce_no` is low exactly while `busy_o` is high. `busy_o` stays high until the cycle in which `done_o` pulses.
- R3: The bytes latched at WE rising edges are, in order: 60h with CLE high, three bytes with ALE high, D0h with CLE high and, after ready/busy has returned high, 70h with CLE high.
- R4: The row address equals block × 64. Address byte k (k = 0, 1, 2) carries bits [8k+7:8k] of the row address. For example, the first byte is {blk[1:0], 6'b0}, the second is blk[9:2] and the third is {7'b0, blk[10]}.
- R5: In every write cycle, CLE or ALE and the data are driven for `T_SETUP` clocks with WE high. WE is then low for `T_WE_LO` clocks. After WE rises, the same CLE, ALE and data are held for `T_HOLD` clocks. CLE and ALE are never high together, and WE and RE are never low together.
- R6: The 70h status command is not issued until ready/busy has been seen low and then high after the confirm byte.
- R7: The status read drives RE low for `T_WE_LO` clocks. If status bit 0 is 0, `pass_o` is set. If it is 1, `fail_o` is set. `done_o` pulses for one cycle.
- R8: If ready/busy has not gone low within `RB_LOW_WIN` clocks of the end of the confirm cycle, `timeout_o` is set, `done_o` pulses and no 70h command is sent.
- R9: If ready/busy stays low for longer than `BUSY_TO` clocks, `timeout_o` is set, `done_o` pulses and no 70h command is sent. A busy time of at most `BUSY_TO` − 8 clocks completes normally.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. The bus carries only the address of the erase already in progress, and only one `done_o` pulse follows.
- R11: Exactly one of `pass_o`, `fail_o` and `timeout_o` is set when `done_o` pulses. That flag holds until the next accepted start. `busy_o` is low on the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| blk_i | input | BLK_W | Block number to erase |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Erase reported success |
| fail_o | output | 1 | Erase reported failure |
| timeout_o | output | 1 | Ready/busy handshake timed out |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_io_o | output | 8 | Bus data out |
| nand_io_oe_o | output | 1 | Bus output enable |
| nand_io_i | input | 8 | Bus data in |
| nand_rb_i | input | 1 | Ready/busy, low while busy |

## Verification
If the sequencer's state register skips a step, the byte log taken at WE rising edges has a missing, duplicated or reordered entry, and this shows within one bus cycle of the error. A wrong phase counter shows as a strobe width or setup/hold count that differs from its parameter in the very next write cycle. A broken handshake or timeout path shows either as a 70h byte sent before ready/busy has cycled, or as a result flag that disagrees with the status byte or with the stuck ready/busy the bench applied. These outcomes are visible at `done_o`, within `BUSY_TO` plus a few dozen clocks.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS      = 8'h70;
  localparam int unsigned ROW_BYTES      = 3;
  localparam int unsigned PAGE_BITS      = 6;

  typedef enum logic [1:0] {
    BK_CMD  = 2'd0,
    BK_ADDR = 2'd1,
    BK_READ = 2'd2
  } bus_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HOLD  = 2'd3
  } bus_phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_ADR0, S_ADR1, S_ADR2, S_CONF,
    S_WLO, S_WHI, S_STAT, S_READ, S_DONE
  } seq_state_e;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rb_i,
  output logic rb_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], rb_i};
  end

  assign rb_o = sync_q[STAGES-1];
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_erase_pkg::*;
#(
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_WE_LO = 2,
  parameter int unsigned T_HOLD  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  bus_kind_e  kind_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] io_i,
  output logic       ack_o,
  output logic [7:0] rdata_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic [7:0] io_o,
  output logic       io_oe_o
);
  localparam int unsigned TMAX_A = (T_SETUP > T_WE_LO) ? T_SETUP : T_WE_LO;
  localparam int unsigned TMAX   = (TMAX_A > T_HOLD) ? TMAX_A : T_HOLD;
  localparam int unsigned TW     = $clog2(TMAX + 1);

  bus_phase_e  phase_q;
  bus_kind_e   kind_q;
  logic [7:0]  data_q;
  logic [TW-1:0] cnt_q, last;
  logic        at_end;

  always_comb begin
    case (phase_q)
      PH_SETUP: last = TW'(T_SETUP - 1);
      PH_LOW:   last = TW'(T_WE_LO - 1);
      PH_HOLD:  last = TW'(T_HOLD - 1);
      default:  last = '0;
    endcase
  end

  assign at_end = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      kind_q  <= BK_CMD;
      data_q  <= '0;
      cnt_q   <= '0;
      rdata_o <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (req_i) begin
          phase_q <= PH_SETUP;
          kind_q  <= kind_i;
          data_q  <= wdata_i;
          cnt_q   <= '0;
        end
        PH_SETUP: if (at_end) begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_LOW: if (at_end) begin
          phase_q <= PH_HOLD;
          cnt_q   <= '0;
          if (kind_q == BK_READ) rdata_o <= io_i;
        end else cnt_q <= cnt_q + 1'b1;
        PH_HOLD: if (at_end) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  logic active, is_read;
  assign active  = (phase_q != PH_IDLE);
  assign is_read = (kind_q == BK_READ);

  assign ack_o   = (phase_q == PH_HOLD) && at_end;
  assign cle_o   = active && (kind_q == BK_CMD);
  assign ale_o   = active && (kind_q == BK_ADDR);
  assign we_no   = !((phase_q == PH_LOW) && !is_read);
  assign re_no   = !((phase_q == PH_LOW) && is_read);
  assign io_oe_o = active && !is_read;
  assign io_o    = data_q;
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int unsigned BLK_W      = 11,
  parameter int unsigned T_SETUP    = 2,
  parameter int unsigned T_WE_LO    = 2,
  parameter int unsigned T_HOLD     = 2,
  parameter int unsigned RB_LOW_WIN = 16,
  parameter int unsigned BUSY_TO    = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             fail_o,
  output logic             timeout_o,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_i
);
  localparam int unsigned ROW_W = ROW_BYTES * 8;

  seq_state_e      state_q;
  logic [BLK_W-1:0] blk_q;
  logic [ROW_W-1:0] row;
  logic            req, ack, rb_s, lo_exp, hi_exp;
  bus_kind_e       kind;
  logic [7:0]      wdata, rdata;
  logic            pass_q, fail_q, to_q;

  assign row = ROW_W'({blk_q, {PAGE_BITS{1'b0}}});

  always_comb begin
    req   = 1'b1;
    kind  = BK_CMD;
    wdata = 8'h00;
    case (state_q)
      S_SETUP: wdata = CMD_ERASE_SETUP;
      S_ADR0:  begin kind = BK_ADDR; wdata = row[7:0];   end
      S_ADR1:  begin kind = BK_ADDR; wdata = row[15:8];  end
      S_ADR2:  begin kind = BK_ADDR; wdata = row[23:16]; end
      S_CONF:  wdata = CMD_ERASE_GO;
      S_STAT:  wdata = CMD_STATUS;
      S_READ:  kind = BK_READ;
      default: req = 1'b0;
    endcase
  end

  nand_bus_cycle #(
    .T_SETUP(T_SETUP), .T_WE_LO(T_WE_LO), .T_HOLD(T_HOLD)
  ) u_cycle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .kind_i  (kind),
    .wdata_i (wdata),
    .io_i    (nand_io_i),
    .ack_o   (ack),
    .rdata_o (rdata),
    .cle_o   (nand_cle_o),
    .ale_o   (nand_ale_o),
    .we_no   (nand_we_no),
    .re_no   (nand_re_no),
    .io_o    (nand_io_o),
    .io_oe_o (nand_io_oe_o)
  );

  nand_rb_sync #(.STAGES(2)) u_rb_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rb_i(nand_rb_i), .rb_o(rb_s)
  );

  nand_wait_timer #(.LIMIT(RB_LOW_WIN)) u_lo_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(state_q == S_WLO), .expired_o(lo_exp)
  );

  nand_wait_timer #(.LIMIT(BUSY_TO)) u_hi_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(state_q == S_WHI), .expired_o(hi_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      blk_q   <= '0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_SETUP;
          blk_q   <= blk_i;
          pass_q  <= 1'b0;
          fail_q  <= 1'b0;
          to_q    <= 1'b0;
        end
        S_SETUP: if (ack) state_q <= S_ADR0;
        S_ADR0:  if (ack) state_q <= S_ADR1;
        S_ADR1:  if (ack) state_q <= S_ADR2;
        S_ADR2:  if (ack) state_q <= S_CONF;
        S_CONF:  if (ack) state_q <= S_WLO;
        S_WLO: begin
          if (!rb_s) state_q <= S_WHI;
          else if (lo_exp) begin
            state_q <= S_DONE;
            to_q    <= 1'b1;
          end
        end
        S_WHI: begin
          if (rb_s) state_q <= S_STAT;
          else if (hi_exp) begin
            state_q <= S_DONE;
            to_q    <= 1'b1;
          end
        end
        S_STAT: if (ack) state_q <= S_READ;
        S_READ: if (ack) begin
          state_q <= S_DONE;
          pass_q  <= !rdata[0];
          fail_q  <= rdata[0];
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign nand_ce_no = !busy_o;
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign timeout_o  = to_q;
endmodule

// File: rtl/nand_erase_seq_chk.sv
module nand_erase_seq_chk #(
  parameter int unsigned BLK_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [BLK_W-1:0] blk_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             pass_o,
  input logic             fail_o,
  input logic             timeout_o,
  input logic             nand_ce_no,
  input logic             nand_cle_o,
  input logic             nand_ale_o,
  input logic             nand_we_no,
  input logic             nand_re_no,
  input logic [7:0]       nand_io_o,
  input logic             nand_io_oe_o,
  input logic [7:0]       nand_io_i,
  input logic             nand_rb_i
);
  p_latch_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));

  p_strobe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));

  p_we_drives_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> (nand_io_oe_o && (nand_cle_o || nand_ale_o)));

  p_data_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nand_we_no) |-> $stable(nand_io_o));

  p_ce_tracks_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_ce_no == !busy_o);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (nand_we_no && nand_re_no && !nand_cle_o && !nand_ale_o));

  p_done_ends_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!busy_o && !done_o));

  p_one_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones({pass_o, fail_o, timeout_o}) == 1));

  p_result_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(fail_o) && $stable(timeout_o)));
endmodule

bind nand_erase_seq nand_erase_seq_chk #(.BLK_W(BLK_W)) u_chk (.*);

// File: tb/nand_erase_seq_test.sv
module nand_erase_seq_test;
  localparam int TS = 2, TL = 2, TH = 2, LWIN = 16, BTO = 64;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [10:0] blk = '0;
  logic busy, done, pass, fail, tmo, ce_n, cle, ale, we_n, re_n, oe;
  logic [7:0] io_o, io_i;
  logic rb = 1'b1;
  logic [7:0] stat_byte = 8'hE0;

  always #2 clk = ~clk;

  assign io_i = !re_n ? stat_byte : 8'h00;

  nand_erase_seq #(
    .BLK_W(11), .T_SETUP(TS), .T_WE_LO(TL), .T_HOLD(TH),
    .RB_LOW_WIN(LWIN), .BUSY_TO(BTO)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .blk_i(blk),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fail_o(fail), .timeout_o(tmo),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_io_o(io_o), .nand_io_oe_o(oe), .nand_io_i(io_i),
    .nand_rb_i(rb)
  );

  int checks = 0, fails = 0, cycle = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model and bus monitor, sampled at the falling edge
  logic [9:0] log_q [0:15];
  int nlog = 0;
  int rb_mode = 0, lo_dly = 3, busy_len = 10, tmr = 0;
  bit armed = 1'b0;
  bit prev_we = 1'b1, prev_act = 1'b0, lowered = 1'b0, prev_re = 1'b1;
  int su = 0, lo = 0, ho = 0, rlo = 0;

  always @(negedge clk) begin
    cycle++;
    if (cycle > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (rst_n) begin
      // R5 strobe timing per write cycle
      if (cle || ale) begin
        if (!we_n) begin lo++; lowered = 1'b1; end
        else if (!lowered) su++;
        else ho++;
      end else if (prev_act) begin
        chk(su == TS, "R5 setup", su, TS);
        chk(lo == TL, "R5 we_low", lo, TL);
        chk(ho == TH, "R5 hold", ho, TH);
        su = 0; lo = 0; ho = 0; lowered = 1'b0;
      end
      prev_act = cle || ale;
      // R7 read strobe width
      if (!re_n) rlo++;
      else if (!prev_re) begin
        chk(rlo == TL, "R7 re_low", rlo, TL);
        rlo = 0;
      end
      prev_re = re_n;
      // capture at WE rising edge
      if (!prev_we && we_n) begin
        if (nlog < 16) log_q[nlog] = {cle, ale, io_o};
        nlog++;
        if (cle && io_o == 8'hD0) begin armed = 1'b1; tmr = 0; end
      end
      prev_we = we_n;
      if (armed) begin
        tmr++;
        if (rb_mode != 1 && tmr == lo_dly) rb = 1'b0;
        if (rb_mode == 0 && tmr == lo_dly + busy_len) begin rb = 1'b1; armed = 1'b0; end
      end
    end
  end

  // res: 0 pass, 1 fail, 2 timeout
  task automatic do_erase(input int b, input int mode, input int ld, input int bl,
                          input logic [7:0] st, input int res, input bit poke);
    int n;
    int nexp;
    int row;
    armed = 1'b0; rb = 1'b1; nlog = 0;
    rb_mode = mode; lo_dly = ld; busy_len = bl; stat_byte = st;
    @(negedge clk); start = 1'b1; blk = 11'(b);
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    chk(ce_n == 1'b0, "R2 ce", ce_n, 0);
    if (poke) begin
      repeat (8) @(negedge clk);
      start = 1'b1; blk = ~11'(b);
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R2 done", done, 1);
    if (res == 2) chk(tmo && !pass && !fail, mode == 1 ? "R8 timeout" : "R9 timeout",
                      {tmo, pass, fail}, 3'b100);
    else chk(!tmo && pass == (res == 0) && fail == (res == 1), "R7 result",
             {tmo, pass, fail}, res == 0 ? 3'b010 : 3'b001);
    @(negedge clk);
    chk(!done && !busy, "R11 single done", {done, busy}, 0);
    chk(pass == (res == 0) && fail == (res == 1) && tmo == (res == 2), "R11 held",
        {tmo, pass, fail}, res == 2 ? 3'b100 : (res == 0 ? 3'b010 : 3'b001));
    if (poke) chk(nlog == 6, "R10 ignored start", nlog, 6);
    nexp = (res == 2) ? 5 : 6;
    chk(nlog == nexp, res == 2 ? "R8 no status cmd" : "R6 byte count", nlog, nexp);
    row = b * 64;
    if (nlog >= 5) begin
      chk(log_q[0] == {2'b10, 8'h60}, "R3 setup", log_q[0], {2'b10, 8'h60});
      for (int k = 0; k < 3; k++)
        chk(log_q[1+k] == {2'b01, 8'((row >> (8*k)) & 255)},
            poke ? "R10 addr" : "R4 addr", log_q[1+k], {2'b01, 8'((row >> (8*k)) & 255)});
      chk(log_q[4] == {2'b10, 8'hD0}, "R3 confirm", log_q[4], {2'b10, 8'hD0});
    end
    if (nlog == 6) chk(log_q[5] == {2'b10, 8'h70}, "R3 status", log_q[5], {2'b10, 8'h70});
    armed = 1'b0; rb = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !fail && !tmo, "R1 outputs", {busy, done, pass, fail, tmo}, 0);
    chk(ce_n && we_n && re_n && !cle && !ale && !oe, "R1 bus",
        {ce_n, we_n, re_n, cle, ale, oe}, 6'b111000);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 11; k++)
      do_erase(1 << k, 0, 1 + (k % 4), 10 + 4 * k, (k % 2) ? 8'hE1 : 8'hE0, k % 2, 1'b0);
    for (int b = 0; b < 2048; b += 97)
      do_erase(b, 0, 3, 20, (b % 2) ? 8'hC1 : 8'hC0, b % 2, 1'b0);
    do_erase(2047, 0, 2, BTO - 8, 8'hE0, 0, 1'b0);   // R9 longest normal busy
    do_erase(11'h555, 0, 3, 30, 8'hE0, 0, 1'b1);      // R10
    do_erase(11'h2AA, 1, 3, 0, 8'hE0, 2, 1'b0);       // R8
    do_erase(11'h123, 2, 3, 0, 8'hE0, 2, 1'b0);       // R9
    do_erase(11'h321, 0, 4, 12, 8'hFE, 0, 1'b0);      // R7 only bit 0 matters
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule